// File: doc/BRIEF.md
# Out-of-Order Store Commit Buffer

This block holds retired stores between the point where they leave the pipeline and the point where they are written into the level-one data cache. A retired store is not visible to other cores. It becomes visible only when it goes out through the commit port. On allocation, each entry sends one ownership request for its cache line, tagged with its slot index. An entry can commit only after the coherence side returns a grant carrying that index.

In relaxed mode, granted entries drain in any order, so a younger store whose line is already held can overtake an older one that is still waiting. Three rules restrict this. A store marked as a release waits until every older entry has left. Two stores to the same line keep their program order. A mode input makes the whole buffer drain strictly from the oldest entry. When several entries may commit in one cycle, the oldest of them goes first, and at most one store commits per cycle.

Top module: `store_buffer_relaxed`

## Requirements
- R1: After synchronous active-high reset, the buffer reports empty (`sb_empty_o`=1, `sb_full_o`=0), accepts stores (`enq_ready_o`=1) and presents no commit.
- R2: A store is accepted in the cycle where `enq_valid_i` and `enq_ready_o` are both high. It occupies the lowest-numbered free slot. In that same cycle, `own_req_valid_o` is high, `own_req_idx_o` holds that slot number and `own_req_line_o` holds the store address shifted right by `LINE_OFF`.
- R3: An entry never commits before a grant (`own_gnt_valid_i` with `own_gnt_idx_i` equal to its slot) has been seen on a clock edge after its allocation. The earliest commit is in the cycle that follows the grant edge.
- R4: In relaxed mode (`strict_fifo_i`=0), a granted entry commits even while an older entry to a different line still lacks its grant.
- R5: At most one entry commits per cycle. When several are eligible, the oldest one commits.
- R6: An entry whose release flag was set at enqueue does not commit while any older entry is still held.
- R7: With `strict_fifo_i`=1, only the oldest held entry may commit. Younger granted entries wait behind it.
- R8: Two entries whose addresses fall in the same line (same address bits above `LINE_OFF`) commit in arrival order in both modes.
- R9: `enq_ready_o` is low and `sb_full_o` is high while all `DEPTH` slots are held. A slot freed by a commit can accept a store in the next cycle.
- R10: While `cmt_valid_o` is high, `cmt_addr_o`, `cmt_data_o` and `cmt_be_o` carry the address, data and byte enables stored with the committing entry.
- R11: A grant whose index names an empty slot has no effect. A store later placed in that slot still waits for its own grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_fifo_i | input | 1 | 1 = drain oldest-first only, 0 = relaxed order |
| enq_valid_i | input | 1 | Retired store offered |
| enq_ready_o | output | 1 | A free slot exists |
| enq_addr_i | input | 32 | Store byte address |
| enq_data_i | input | 32 | Store data |
| enq_be_i | input | 4 | Store byte enables |
| enq_rel_i | input | 1 | Store carries release ordering |
| own_req_valid_o | output | 1 | Ownership request for the newly allocated slot |
| own_req_idx_o | output | 2 | Slot index tagging the request |
| own_req_line_o | output | 26 | Line address of the request |
| own_gnt_valid_i | input | 1 | Exclusive ownership granted |
| own_gnt_idx_i | input | 2 | Slot index the grant belongs to |
| cmt_valid_o | output | 1 | A store is written to the cache this cycle |
| cmt_addr_o | output | 32 | Address of the committing store |
| cmt_data_o | output | 32 | Data of the committing store |
| cmt_be_o | output | 4 | Byte enables of the committing store |
| sb_full_o | output | 1 | All slots held |
| sb_empty_o | output | 1 | No slot held |

## Verification
Two events can land in the same cycle: a grant that makes a younger entry eligible, and an older entry that is held back by ordering. The first case is a grant arriving while a release, same-line or strict-mode barrier still blocks the entry it names. The second case is a commit of one slot while the buffer is full and a store is waiting to enter. The bench sets up each case by ordering grants against enqueues. It then checks, cycle by cycle, that the commit port stays silent or presents exactly the oldest entry that is allowed to leave. It also checks that the ready signal rises only in the cycle after the slot is freed.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_ADDR_W = 32;
    localparam int unsigned SB_DATA_W = 32;
    localparam int unsigned SB_BE_W   = SB_DATA_W / 8;

    // Payload of one buffered store
    typedef struct packed {
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
        logic [SB_BE_W-1:0]   be;
    } sb_entry_t;

    typedef enum logic {
        ORD_RELAXED = 1'b0,
        ORD_STRICT  = 1'b1
    } sb_order_e;

    function automatic logic same_line(input logic [SB_ADDR_W-1:0] a,
                                       input logic [SB_ADDR_W-1:0] b,
                                       input int unsigned          off);
        return (a >> off) == (b >> off);
    endfunction

endpackage

// File: rtl/sb_free_pick.sv
module sb_free_pick #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid_i,
    output logic             any_free_o,
    output logic [DEPTH-1:0] free_oh_o,
    output logic [IDX_W-1:0] free_idx_o
);

    // Lowest-numbered free slot wins
    always_comb begin
        free_oh_o  = '0;
        free_idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_oh_o  = '0;
                free_oh_o[i] = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
        any_free_o = ~&valid_i;
    end

endmodule

// File: rtl/sb_age_track.sv
module sb_age_track #(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0]             valid_i,
    input  logic [DEPTH-1:0]             alloc_oh_i,
    input  logic [DEPTH-1:0]             free_oh_i,
    // older_o[i][j] = 1 when slot j was allocated before slot i
    output logic [DEPTH-1:0][DEPTH-1:0]  older_o
);

    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (alloc_oh_i[i]) begin
                        older_q[i][k] <= valid_i[k] & ~free_oh_i[k];
                    end else if (alloc_oh_i[k]) begin
                        older_q[i][k] <= 1'b0;
                    end
                end
            end
        end
    end

    assign older_o = older_q;

endmodule

// File: rtl/sb_commit_pick.sv
module sb_commit_pick #(
    parameter int unsigned DEPTH = 4
) (
    input  logic                        strict_i,
    input  logic [DEPTH-1:0]            valid_i,
    input  logic [DEPTH-1:0]            owned_i,
    input  logic [DEPTH-1:0]            rel_i,
    input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
    input  logic [DEPTH-1:0][DEPTH-1:0] line_eq_i,
    output logic [DEPTH-1:0]            sel_oh_o
);

    logic [DEPTH-1:0] eligible;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [DEPTH-1:0] live_older;
            logic             older_held;
            logic             line_block;
            assign live_older = older_i[i] & valid_i;
            assign older_held = |live_older;
            assign line_block = |(live_older & line_eq_i[i]);
            assign eligible[i] = valid_i[i] & owned_i[i] & ~line_block
                               & ~(rel_i[i] & older_held)
                               & ~(strict_i & older_held);
            // Oldest eligible entry only
            assign sel_oh_o[i] = eligible[i] & ~|(older_i[i] & eligible);
        end
    endgenerate

endmodule

// File: rtl/store_buffer_relaxed.sv
module store_buffer_relaxed
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned LINE_OFF = 6,
    localparam int unsigned IDX_W   = $clog2(DEPTH),
    localparam int unsigned LINE_W  = SB_ADDR_W - LINE_OFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strict_fifo_i,
    input  logic                 enq_valid_i,
    output logic                 enq_ready_o,
    input  logic [SB_ADDR_W-1:0] enq_addr_i,
    input  logic [SB_DATA_W-1:0] enq_data_i,
    input  logic [SB_BE_W-1:0]   enq_be_i,
    input  logic                 enq_rel_i,
    output logic                 own_req_valid_o,
    output logic [IDX_W-1:0]     own_req_idx_o,
    output logic [LINE_W-1:0]    own_req_line_o,
    input  logic                 own_gnt_valid_i,
    input  logic [IDX_W-1:0]     own_gnt_idx_i,
    output logic                 cmt_valid_o,
    output logic [SB_ADDR_W-1:0] cmt_addr_o,
    output logic [SB_DATA_W-1:0] cmt_data_o,
    output logic [SB_BE_W-1:0]   cmt_be_o,
    output logic                 sb_full_o,
    output logic                 sb_empty_o
);

    sb_entry_t                   ent_q [DEPTH];
    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0]            rdy_q;
    logic [DEPTH-1:0]            rel_q;
    logic [DEPTH-1:0]            free_oh;
    logic [DEPTH-1:0]            alloc_oh;
    logic [DEPTH-1:0]            cmt_oh;
    logic [IDX_W-1:0]            alloc_idx;
    logic                        any_free;
    logic                        enq_fire;
    logic [DEPTH-1:0][DEPTH-1:0] older_q;
    logic [DEPTH-1:0][DEPTH-1:0] line_eq;
    sb_order_e                   order_mode;

    assign order_mode = sb_order_e'(strict_fifo_i);

    sb_free_pick #(.DEPTH(DEPTH)) u_free (
        .valid_i    (valid_q),
        .any_free_o (any_free),
        .free_oh_o  (free_oh),
        .free_idx_o (alloc_idx)
    );

    assign enq_ready_o = any_free;
    assign enq_fire    = enq_valid_i & any_free;
    assign alloc_oh    = free_oh & {DEPTH{enq_fire}};

    // Ownership request leaves with the allocation (R2)
    assign own_req_valid_o = enq_fire;
    assign own_req_idx_o   = alloc_idx;
    assign own_req_line_o  = enq_addr_i[SB_ADDR_W-1:LINE_OFF];

    sb_age_track #(.DEPTH(DEPTH)) u_age (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_q),
        .alloc_oh_i (alloc_oh),
        .free_oh_i  (cmt_oh),
        .older_o    (older_q)
    );

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_row
            for (genvar k = 0; k < DEPTH; k++) begin : g_col
                assign line_eq[i][k] = same_line(ent_q[i].addr, ent_q[k].addr, LINE_OFF);
            end
        end
    endgenerate

    sb_commit_pick #(.DEPTH(DEPTH)) u_pick (
        .strict_i  (order_mode == ORD_STRICT),
        .valid_i   (valid_q),
        .owned_i   (rdy_q),
        .rel_i     (rel_q),
        .older_i   (older_q),
        .line_eq_i (line_eq),
        .sel_oh_o  (cmt_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rdy_q   <= '0;
            rel_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_oh[i]) begin
                    valid_q[i] <= 1'b1;
                    rdy_q[i]   <= 1'b0;
                    rel_q[i]   <= enq_rel_i;
                end else if (cmt_oh[i]) begin
                    valid_q[i] <= 1'b0;
                    rdy_q[i]   <= 1'b0;
                    rel_q[i]   <= 1'b0;
                end else if (own_gnt_valid_i && valid_q[i]
                             && own_gnt_idx_i == IDX_W'(i)) begin
                    rdy_q[i] <= 1'b1;   // R11: empty slot ignores grant
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_oh[i]) begin
                ent_q[i].addr <= enq_addr_i;
                ent_q[i].data <= enq_data_i;
                ent_q[i].be   <= enq_be_i;
            end
        end
    end

    // One-hot commit mux (R10)
    always_comb begin
        cmt_addr_o = '0;
        cmt_data_o = '0;
        cmt_be_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cmt_oh[i]) begin
                cmt_addr_o = cmt_addr_o | ent_q[i].addr;
                cmt_data_o = cmt_data_o | ent_q[i].data;
                cmt_be_o   = cmt_be_o   | ent_q[i].be;
            end
        end
    end

    assign cmt_valid_o = |cmt_oh;
    assign sb_full_o   = &valid_q;
    assign sb_empty_o  = ~|valid_q;

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        strict_fifo_i,
    input logic                        enq_valid_i,
    input logic                        enq_ready_o,
    input logic                        own_req_valid_o,
    input logic                        sb_full_o,
    input logic [DEPTH-1:0]            valid_q,
    input logic [DEPTH-1:0]            rdy_q,
    input logic [DEPTH-1:0]            rel_q,
    input logic [DEPTH-1:0]            cmt_oh,
    input logic [DEPTH-1:0][DEPTH-1:0] older_q
);

    assert_one_commit_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmt_oh));

    assert_full_stall_R9: assert property (@(posedge clk) disable iff (rst)
        sb_full_o |-> !enq_ready_o);

    assert_req_on_enq_R2: assert property (@(posedge clk) disable iff (rst)
        (enq_valid_i && enq_ready_o) |-> own_req_valid_o);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_chk
            assert_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
                cmt_oh[i] |-> rdy_q[i]);

            assert_release_barrier_R6: assert property (@(posedge clk) disable iff (rst)
                (cmt_oh[i] && rel_q[i]) |-> ((older_q[i] & valid_q) == '0));

            assert_strict_head_R7: assert property (@(posedge clk) disable iff (rst)
                (cmt_oh[i] && strict_fifo_i) |-> ((older_q[i] & valid_q) == '0));

            assert_slot_freed_R9: assert property (@(posedge clk) disable iff (rst)
                cmt_oh[i] |=> !valid_q[i]);
        end
    endgenerate

endmodule

bind store_buffer_relaxed sb_chk #(.DEPTH(DEPTH)) u_sb_chk (
    .clk             (clk),
    .rst             (rst),
    .strict_fifo_i   (strict_fifo_i),
    .enq_valid_i     (enq_valid_i),
    .enq_ready_o     (enq_ready_o),
    .own_req_valid_o (own_req_valid_o),
    .sb_full_o       (sb_full_o),
    .valid_q         (valid_q),
    .rdy_q           (rdy_q),
    .rel_q           (rel_q),
    .cmt_oh          (cmt_oh),
    .older_q         (older_q)
);

// File: tb/tb_store_buffer_relaxed.sv
`timescale 1ns/1ps
module tb_store_buffer_relaxed;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strict_fifo_i = 1'b0;
    logic        enq_valid_i = 1'b0;
    logic        enq_ready_o;
    logic [31:0] enq_addr_i = '0;
    logic [31:0] enq_data_i = '0;
    logic [3:0]  enq_be_i = '0;
    logic        enq_rel_i = 1'b0;
    logic        own_req_valid_o;
    logic [1:0]  own_req_idx_o;
    logic [25:0] own_req_line_o;
    logic        own_gnt_valid_i = 1'b0;
    logic [1:0]  own_gnt_idx_i = '0;
    logic        cmt_valid_o;
    logic [31:0] cmt_addr_o;
    logic [31:0] cmt_data_o;
    logic [3:0]  cmt_be_o;
    logic        sb_full_o;
    logic        sb_empty_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    store_buffer_relaxed dut (.*);

    typedef struct packed {
        logic       e;   logic [11:0] a;  logic [7:0] d;  logic [3:0] be;
        logic       rel; logic        g;  logic [1:0] gi; logic       s;
        logic       xr;  logic        xc; logic [11:0] xa; logic [7:0] xd;
        logic [3:0] xbe; logic [1:0]  xi; logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(logic e, logic [11:0] a, logic [7:0] d, logic [3:0] be,
                                logic rel, logic g, logic [1:0] gi, logic s,
                                logic xr, logic xc, logic [11:0] xa, logic [7:0] xd,
                                logic [3:0] xbe, logic [1:0] xi, logic [3:0] rq);
        return '{e, a, d, be, rel, g, gi, s, xr, xc, xa, xd, xbe, xi, rq};
    endfunction

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        mk(1,'h100,1,'hF,0, 0,0,0, 1,0,0,0,0,0, 2),    // R2 slot0
        mk(1,'h200,2,'hF,0, 0,0,0, 1,0,0,0,0,1, 2),    // R2 slot1
        mk(0,0,0,0,0,       1,1,0, 1,0,0,0,0,0, 3),    // R3 grant slot1
        mk(0,0,0,0,0,       0,0,0, 1,1,'h200,2,'hF,0, 4), // R4 younger first
        mk(0,0,0,0,0,       1,0,0, 1,0,0,0,0,0, 3),    // R3
        mk(0,0,0,0,0,       0,0,0, 1,1,'h100,1,'hF,0, 10),
        mk(0,0,0,0,0,       0,0,0, 1,0,0,0,0,0, 3),
        mk(1,'h100,3,'hF,0, 0,0,0, 1,0,0,0,0,0, 2),    // R6 setup
        mk(1,'h280,4,'hF,1, 0,0,0, 1,0,0,0,0,1, 2),    // release store
        mk(0,0,0,0,0,       1,1,0, 1,0,0,0,0,0, 6),
        mk(0,0,0,0,0,       1,0,0, 1,0,0,0,0,0, 6),    // R6 release held
        mk(0,0,0,0,0,       0,0,0, 1,1,'h100,3,'hF,0, 5), // R5 oldest
        mk(0,0,0,0,0,       0,0,0, 1,1,'h280,4,'hF,0, 6),
        mk(0,0,0,0,0,       0,0,0, 1,0,0,0,0,0, 6),
        mk(1,'h100,5,'hF,0, 0,0,1, 1,0,0,0,0,0, 7),    // R7 strict
        mk(1,'h200,6,'hF,0, 0,0,1, 1,0,0,0,0,1, 7),
        mk(0,0,0,0,0,       1,1,1, 1,0,0,0,0,0, 7),
        mk(0,0,0,0,0,       1,0,1, 1,0,0,0,0,0, 7),    // R7 younger waits
        mk(0,0,0,0,0,       0,0,0, 1,1,'h100,5,'hF,0, 5), // R5 both ready
        mk(0,0,0,0,0,       0,0,0, 1,1,'h200,6,'hF,0, 5),
        mk(0,0,0,0,0,       0,0,0, 1,0,0,0,0,0, 5),
        mk(1,'h100,7,'hF,0, 0,0,0, 1,0,0,0,0,0, 8),    // R8 same line
        mk(1,'h108,8,'h3,0, 0,0,0, 1,0,0,0,0,1, 8),
        mk(0,0,0,0,0,       1,1,0, 1,0,0,0,0,0, 8),
        mk(0,0,0,0,0,       1,0,0, 1,0,0,0,0,0, 8),    // R8 younger held
        mk(0,0,0,0,0,       0,0,0, 1,1,'h100,7,'hF,0, 8),
        mk(0,0,0,0,0,       0,0,0, 1,1,'h108,8,'h3,0, 10), // R10 be
        mk(0,0,0,0,0,       0,0,0, 1,0,0,0,0,0, 8),
        mk(1,'h000,9,'hF,0, 0,0,0, 1,0,0,0,0,0, 9),    // R9 fill
        mk(1,'h040,10,'hF,0,0,0,0, 1,0,0,0,0,1, 9),
        mk(1,'h080,11,'hF,0,0,0,0, 1,0,0,0,0,2, 9),
        mk(1,'h0C0,12,'hF,0,0,0,0, 1,0,0,0,0,3, 9),
        mk(1,'h100,13,'hF,0,1,2,0, 0,0,0,0,0,0, 9),    // R9 full
        mk(1,'h100,13,'hF,0,0,0,0, 0,1,'h080,11,'hF,0, 9),
        mk(1,'h100,13,'hF,0,0,0,0, 1,0,0,0,0,2, 9),    // R9 reuse
        mk(0,0,0,0,0,       0,0,0, 0,0,0,0,0,0, 9)
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        enq_valid_i = 1'b0; enq_rel_i = 1'b0; own_gnt_valid_i = 1'b0;
        strict_fifo_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 empty", 32'(sb_empty_o), 1);
        check("R1 ready", 32'(enq_ready_o), 1);
        check("R1 commit", 32'(cmt_valid_o), 0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            enq_valid_i     = VECS[v].e;
            enq_addr_i      = 32'(VECS[v].a);
            enq_data_i      = 32'(VECS[v].d);
            enq_be_i        = VECS[v].be;
            enq_rel_i       = VECS[v].rel;
            own_gnt_valid_i = VECS[v].g;
            own_gnt_idx_i   = VECS[v].gi;
            strict_fifo_i   = VECS[v].s;
            #1;
            tag = $sformatf("R%0d vec%0d", VECS[v].rq, v);
            check({tag, " ready"}, 32'(enq_ready_o), 32'(VECS[v].xr));
            check({tag, " cmt"}, 32'(cmt_valid_o), 32'(VECS[v].xc));
            if (VECS[v].xc) begin
                check({tag, " addr"}, cmt_addr_o, 32'(VECS[v].xa));
                check({tag, " data"}, cmt_data_o, 32'(VECS[v].xd));
                check({tag, " be"},   32'(cmt_be_o), 32'(VECS[v].xbe));
            end
            if (VECS[v].e) begin
                check({tag, " req"}, 32'(own_req_valid_o), 32'(VECS[v].xr));
                if (VECS[v].xr) begin
                    check({tag, " idx"}, 32'(own_req_idx_o), 32'(VECS[v].xi));
                    check({tag, " line"}, 32'(own_req_line_o), 32'(VECS[v].a) >> 6);
                end
            end
        end
        check("R9 full flag", 32'(sb_full_o), 1);

        // R1: reset from a full buffer
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 empty after reset", 32'(sb_empty_o), 1);
        check("R1 not full", 32'(sb_full_o), 0);
        check("R1 ready after reset", 32'(enq_ready_o), 1);
        check("R1 no commit", 32'(cmt_valid_o), 0);

        // R11: grant to an empty slot is dropped
        @(negedge clk);
        own_gnt_valid_i = 1'b1; own_gnt_idx_i = 2'd0;
        @(negedge clk);
        own_gnt_valid_i = 1'b0;
        enq_valid_i = 1'b1; enq_addr_i = 32'h300; enq_data_i = 32'h55;
        enq_be_i = 4'hF;
        #1;
        check("R11 slot0 alloc", 32'(own_req_idx_o), 0);
        @(negedge clk);
        enq_valid_i = 1'b0;
        #1;
        check("R11 no commit 1", 32'(cmt_valid_o), 0);
        @(negedge clk);
        #1;
        check("R11 no commit 2", 32'(cmt_valid_o), 0);
        own_gnt_valid_i = 1'b1; own_gnt_idx_i = 2'd0;
        @(negedge clk);
        own_gnt_valid_i = 1'b0;
        #1;
        check("R3 commit after grant", 32'(cmt_valid_o), 1);
        check("R10 commit data", cmt_data_o, 32'h55);
        @(negedge clk);
        #1;
        check("R9 empty after drain", 32'(sb_empty_o), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule